// File: doc/BRIEF.md
# Dual Interval Timer with Identification Bytes

This block places two identical down-counting timer channels behind one 4 KB register window. A word access at the bottom of the window reaches channel 0; the next 32-byte slot reaches channel 1. The top eight words of the window return fixed identification bytes. Every other location reads as zero, including the two integration-test words, which have no function. Each channel counts on its own tick-enable input, so the two channels can run at unrelated rates.

Each channel has a 7-bit control field, a reload value and a counter. When the counter steps while it is at zero, the channel expires. On expiry it sets its raw interrupt flag, then reloads, wraps or halts according to its mode. The two masked channel interrupts are available separately and also ORed into one combined line. Read data is registered.

Top module: `dual_timer`

## Requirements
- R1: Decoding uses word addresses, so addr[1:0] is ignored. Byte offsets 0x00–0x1F select channel 0. Offsets 0x20–0x3F select channel 1, and the channel sees offset minus 0x20. Inside a channel the word registers are: 0x00 reload (write also loads the counter), 0x04 counter (read-only), 0x08 control, 0x0C interrupt clear (write-only), 0x10 raw flag, 0x14 masked flag, 0x18 background reload.
- R2: Offsets 0xFE0, 0xFE4, … 0xFFC return the identification bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. Each byte is in bits [7:0], and bits [31:8] are zero.
- R3: Reads of 0xF00, 0xF04 and any other unmapped offset return zero. Writes at offsets 0x40 and above change nothing.
- R4: rdata is loaded on the clock edge where rd_en is high and holds its value until the next read.
- R5: After reset, each channel's control reads 0x02 (interrupt enable only), and its reload, counter and raw flag read zero.
- R6: Control bit layout: bit0 run, bit1 interrupt enable, bit2 32-bit width (0 = 16-bit), bit3 one-shot, bit4 periodic, bits[6:5] prescale. Prescale 0 and 3 mean divide-by-1, 1 means divide-by-16, and 2 means divide-by-256. A control write restarts the prescaler.
- R7: While run is set, a step happens on every Nth cycle with the channel's tick high, where N is the prescale divisor. A step at a non-zero count decrements it. A stopped channel holds its count.
- R8: A step at count zero is an expiry and sets the raw flag. In periodic mode the counter then reloads from the reload value.
- R9: In free-running mode (neither one-shot nor periodic), expiry wraps the counter to all ones of the active width (0xFFFF or 0xFFFFFFFF). In 16-bit mode the counter reads with bits [31:16] zero.
- R10: In one-shot mode (which takes priority over periodic), expiry leaves the counter at zero and clears the run bit.
- R11: A reload write sets both the reload value and the counter. A background-reload write sets only the reload value. Writes to the counter register are ignored.
- R12: A channel interrupt is its raw flag ANDed with its interrupt-enable bit, and the masked-flag register reads the same value. A write to the clear register drops the raw flag, but an expiry in the same cycle wins.
- R13: irq_any is the OR of irq0 and irq1. Ticks on one channel's input never move the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick0 | input | 1 | Count enable, channel 0 |
| tick1 | input | 1 | Count enable, channel 1 |
| irq0 | output | 1 | Masked interrupt, channel 0 |
| irq1 | output | 1 | Masked interrupt, channel 1 |
| irq_any | output | 1 | OR of both channel interrupts |

## Verification
The bench covers the expiry boundary in each mode:
- A periodic channel must show its reload value on the step after zero, not one step early or late.
- A free-running 16-bit channel must wrap to 0xFFFF rather than 0xFFFFFFFF.
- A one-shot channel must stay at zero and report its run bit cleared.

It checks that channel 1 stays still while channel 0 ticks, that a write at 0x40 does not alias onto channel 0, and that a counter write or a background-reload write leaves the counter alone. It also checks that a clear arriving in the same cycle as an expiry leaves the flag set. The prescaler must step on exactly the 16th and 256th tick after a control write.

// File: rtl/dualtmr_pkg.sv
package dualtmr_pkg;

  localparam int CTL_W = 7;

  typedef struct packed {
    logic [1:0] prescale;
    logic       periodic;
    logic       oneshot;
    logic       wide;
    logic       irq_en;
    logic       run;
  } tctl_t;

  localparam tctl_t CTL_RESET = '{prescale: 2'b00, periodic: 1'b0, oneshot: 1'b0,
                                  wide: 1'b0, irq_en: 1'b1, run: 1'b0};

  typedef enum logic [2:0] {
    RG_LOAD   = 3'd0,
    RG_COUNT  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_CLEAR  = 3'd3,
    RG_RAW    = 3'd4,
    RG_MASKED = 3'd5,
    RG_BGLOAD = 3'd6,
    RG_NONE   = 3'd7
  } treg_e;

endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int PRE_W = 8,
  parameter int LO_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       step
);
  localparam logic [PRE_W-1:0] LO_MASK = {{(PRE_W-LO_W){1'b0}}, {LO_W{1'b1}}};
  localparam logic [PRE_W-1:0] HI_MASK = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    unique case (sel)
      2'd1:    mask = LO_MASK;
      2'd2:    mask = HI_MASK;
      default: mask = '0;
    endcase
  end

  assign step = en && tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)       pre_q <= '0;
    else if (en && tick)  pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/dt_id_rom.sv
module dt_id_rom (
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);
  always_comb begin
    unique case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end
endmodule

// File: rtl/dt_channel.sv
module dt_channel
  import dualtmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8,
  parameter int PRE_LO   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] FULL_MASK   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  tctl_t             ctl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  logic              raw_q;

  treg_e             sel;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] cnt_eff;
  logic              ctl_wr, load_wr, bg_wr, clr_wr;
  logic              step, expire;

  assign sel     = treg_e'(idx);
  assign ctl_wr  = wr_en && (sel == RG_CTRL);
  assign load_wr = wr_en && (sel == RG_LOAD);
  assign bg_wr   = wr_en && (sel == RG_BGLOAD);
  assign clr_wr  = wr_en && (sel == RG_CLEAR);
  assign wmask   = ctl_q.wide ? FULL_MASK : NARROW_MASK;
  assign cnt_eff = cnt_q & wmask;

  dt_prescaler #(.PRE_W(PRE_W), .LO_W(PRE_LO)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (ctl_wr),
    .en   (ctl_q.run),
    .tick (tick),
    .sel  (ctl_q.prescale),
    .step (step)
  );

  assign expire = step && (cnt_eff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RESET;
      load_q <= '0;
      cnt_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (ctl_wr)                       ctl_q     <= tctl_t'(wdata[CTL_W-1:0]);
      else if (expire && ctl_q.oneshot) ctl_q.run <= 1'b0;

      if (load_wr || bg_wr) load_q <= wdata;

      if (load_wr) begin
        cnt_q <= wdata;
      end else if (step) begin
        if (cnt_eff == '0) begin
          if (ctl_q.oneshot)       cnt_q <= '0;
          else if (ctl_q.periodic) cnt_q <= load_q;
          else                     cnt_q <= wmask;
        end else begin
          cnt_q <= (cnt_eff - 1'b1) & wmask;
        end
      end

      if (expire)      raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
    end
  end

  assign irq = raw_q && ctl_q.irq_en;

  always_comb begin
    unique case (sel)
      RG_LOAD, RG_BGLOAD: rdata = load_q;
      RG_COUNT:           rdata = cnt_eff;
      RG_CTRL:            rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      RG_RAW:             rdata = {{(DATA_W-1){1'b0}}, raw_q};
      RG_MASKED:          rdata = {{(DATA_W-1){1'b0}}, irq};
      default:            rdata = '0;
    endcase
  end

  AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && cnt_eff != '0) |=> (cnt_eff == $past(cnt_eff) - 1'b1)); // R7

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.run && !wr_en) |=> $stable(cnt_eff)); // R7

  AST_RAW_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q) |-> $past(step && cnt_eff == '0)); // R8

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (expire && ctl_q.oneshot && !wr_en) |=> (!ctl_q.run && cnt_eff == '0)); // R10

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dualtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int PRE_W  = 8,
  parameter int PRE_LO = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick0,
  input  logic              tick1,
  output logic              irq0,
  output logic              irq1,
  output logic              irq_any
);
  localparam int NCH   = 2;
  localparam int IDX_W = 3;
  localparam int BLK_W = ADDR_W - 2 - IDX_W;
  localparam logic [BLK_W-1:0] ID_BLK = {BLK_W{1'b1}};

  logic [BLK_W-1:0]  blk;
  logic [IDX_W-1:0]  idx;
  logic [NCH-1:0]    ch_sel;
  logic [NCH-1:0]    tick_vec;
  logic [NCH-1:0]    irq_vec;
  logic [DATA_W-1:0] ch_rdata [NCH];
  logic [7:0]        id_byte;
  logic [DATA_W-1:0] rd_next;

  assign blk      = addr[ADDR_W-1 -: BLK_W];
  assign idx      = addr[2 +: IDX_W];
  assign tick_vec = {tick1, tick0};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i] = (blk == BLK_W'(i));
    dt_channel #(
      .DATA_W   (DATA_W),
      .NARROW_W (DATA_W / 2),
      .PRE_W    (PRE_W),
      .PRE_LO   (PRE_LO)
    ) u_ch (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en && ch_sel[i]),
      .idx   (idx),
      .wdata (wdata),
      .tick  (tick_vec[i]),
      .rdata (ch_rdata[i]),
      .irq   (irq_vec[i])
    );
  end

  dt_id_rom u_id (
    .idx     (idx),
    .id_byte (id_byte)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) rd_next = ch_rdata[i];
    end
    if (blk == ID_BLK) rd_next = {{(DATA_W-8){1'b0}}, id_byte};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign irq0    = irq_vec[0];
  assign irq1    = irq_vec[1];
  assign irq_any = |irq_vec;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R4

  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && blk == ID_BLK) |=> (rdata[DATA_W-1:8] == '0)); // R2

endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick0 = 1'b0, tick1 = 1'b0;
  logic        irq0, irq1, irq_any;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_timer u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick0(tick0), .tick1(tick1),
    .irq0(irq0), .irq1(irq1), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ticks(input int ch, input int n);
    @(negedge clk);
    if (ch == 0) tick0 = 1'b1; else tick1 = 1'b1;
    repeat (n) @(negedge clk);
    tick0 = 1'b0; tick1 = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 irq_any", {31'd0, irq_any}, 0);
    rchk("R5 ctrl0", 12'h008, 32'h02);
    rchk("R5 ctrl1", 12'h028, 32'h02);
    rchk("R5 load0", 12'h000, 0);
    rchk("R5 count1", 12'h024, 0);
    rchk("R5 raw0", 12'h010, 0);
  endtask

  task automatic t_ids();
    logic [7:0] exp_id [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) rchk("R2 id byte", 12'hFE0 + 12'(4 * i), {24'd0, exp_id[i]});
    rchk("R1 low addr bits ignored", 12'hFE7, 32'h18);
    rchk("R3 test reg F00", 12'hF00, 0);
    rchk("R3 test reg F04", 12'hF04, 0);
    rchk("R3 unmapped 040", 12'h040, 0);
    rchk("R3 unmapped 7FC", 12'h7FC, 0);
  endtask

  task automatic t_rdata_hold();
    logic [31:0] v;
    rd(12'hFE4, v);
    wr(12'h000, 32'h0);
    @(negedge clk);
    chk("R4 rdata holds", rdata, 32'h18);
  endtask

  task automatic t_periodic();
    wr(12'h000, 3);
    wr(12'h008, 32'h17);
    ticks(0, 3);
    rchk("R7 count after 3 steps", 12'h004, 0);
    chk("R8 no irq before expiry", {31'd0, irq0}, 0);
    ticks(0, 1);
    chk("R8 irq0 on expiry", {31'd0, irq0}, 1);
    chk("R13 irq_any", {31'd0, irq_any}, 1);
    chk("R13 irq1 quiet", {31'd0, irq1}, 0);
    rchk("R8 periodic reload", 12'h004, 3);
    rchk("R12 masked flag", 12'h014, 1);
    wr(12'h00C, 0);
    chk("R12 clear drops irq0", {31'd0, irq0}, 0);
    rchk("R12 raw cleared", 12'h010, 0);
    wr(12'h008, 32'h16);
  endtask

  task automatic t_channel1();
    wr(12'h020, 2);
    wr(12'h028, 32'h15);
    ticks(0, 5);
    rchk("R13 ch1 ignores tick0", 12'h024, 2);
    ticks(1, 3);
    rchk("R1 ch1 raw via 0x30", 12'h030, 1);
    rchk("R12 ch1 masked off", 12'h034, 0);
    chk("R12 irq1 masked", {31'd0, irq1}, 0);
    chk("R13 irq_any low", {31'd0, irq_any}, 0);
    rchk("R8 ch1 reload", 12'h024, 2);
    wr(12'h028, 32'h17);
    chk("R12 irq1 on enable", {31'd0, irq1}, 1);
    chk("R13 irq_any from ch1", {31'd0, irq_any}, 1);
    wr(12'h02C, 0);
    chk("R13 irq_any after clear", {31'd0, irq_any}, 0);
    wr(12'h028, 32'h16);
    rchk("R1 ch0 untouched by ch1", 12'h000, 3);
  endtask

  task automatic t_freerun();
    wr(12'h000, 2);
    wr(12'h008, 32'h03);
    ticks(0, 3);
    rchk("R9 wrap to 0xFFFF", 12'h004, 32'h0000FFFF);
    chk("R8 free-run irq", {31'd0, irq0}, 1);
    ticks(0, 1);
    rchk("R9 decrement after wrap", 12'h004, 32'h0000FFFE);
    wr(12'h008, 32'h02);
    wr(12'h000, 32'h00012345);
    rchk("R9 narrow count view", 12'h004, 32'h00002345);
    rchk("R11 reload full width", 12'h000, 32'h00012345);
    wr(12'h00C, 0);
  endtask

  task automatic t_oneshot();
    wr(12'h000, 1);
    wr(12'h008, 32'h0F);
    ticks(0, 2);
    rchk("R10 one-shot at zero", 12'h004, 0);
    rchk("R10 run bit cleared", 12'h008, 32'h0E);
    rchk("R8 one-shot raw", 12'h010, 1);
    ticks(0, 3);
    rchk("R10 stays at zero", 12'h004, 0);
    wr(12'h00C, 0);
  endtask

  task automatic t_prescale();
    wr(12'h000, 5);
    wr(12'h008, 32'h35);
    ticks(0, 15);
    rchk("R6 div16 before 16th tick", 12'h004, 5);
    ticks(0, 1);
    rchk("R6 div16 on 16th tick", 12'h004, 4);
    wr(12'h008, 32'h55);
    ticks(0, 255);
    rchk("R6 div256 before 256th tick", 12'h004, 4);
    ticks(0, 1);
    rchk("R6 div256 on 256th tick", 12'h004, 3);
    wr(12'h008, 32'h14);
  endtask

  task automatic t_loads();
    wr(12'h004, 32'h99);
    rchk("R11 counter write ignored", 12'h004, 3);
    wr(12'h018, 7);
    rchk("R11 bg load keeps count", 12'h004, 3);
    rchk("R11 bg load reload value", 12'h000, 7);
    rchk("R11 bg register readback", 12'h018, 7);
    wr(12'h008, 32'h15);
    ticks(0, 3);
    rchk("R11 count reaches zero", 12'h004, 0);
    ticks(0, 1);
    rchk("R11 reload uses bg value", 12'h004, 7);
    wr(12'h008, 32'h14);
    wr(12'h00C, 0);
  endtask

  task automatic t_ignored();
    wr(12'h040, 32'hAA);
    wr(12'h800, 32'hBB);
    wr(12'hFE0, 32'h0);
    rchk("R3 ch0 reload unchanged", 12'h000, 7);
    rchk("R3 ch1 reload unchanged", 12'h020, 2);
    rchk("R3 id unchanged", 12'hFE0, 32'h04);
    rchk("R3 ch0 ctrl unchanged", 12'h008, 32'h14);
  endtask

  task automatic t_clear_race();
    wr(12'h000, 0);
    wr(12'h008, 32'h15);
    wr(12'h00C, 0);
    rchk("R12 raw cleared before race", 12'h010, 0);
    @(negedge clk); tick0 = 1'b1; wr_en = 1'b1; addr = 12'h00C; wdata = 0;
    @(negedge clk); tick0 = 1'b0; wr_en = 1'b0;
    rchk("R12 expiry beats clear", 12'h010, 1);
    wr(12'h008, 32'h14);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ids();
    t_rdata_hold();
    t_periodic();
    t_channel1();
    t_freerun();
    t_oneshot();
    t_prescale();
    t_loads();
    t_ignored();
    t_clear_race();
    finish_run();
  end
endmodule